// File: doc/BRIEF.md
# Clock-Sweep Maximum Frequency Finder

This block searches for the shortest test period at which a combinational adder still finishes its worst-case carry ripple. A loadable down-counter runs on the fast master clock. Each time it reaches its terminal count it marks one secondary tick, so the secondary period is exactly the loaded count in master cycles. On every secondary tick a two-phase stimulus sequencer toggles between clearing the adder operands and applying the worst-case input 1 + all-ones. That input forces a carry through every bit position, and the adder's carry out is the only completion indicator the block watches.

A sweep begins on a start pulse with a programmable maximum count. A phase pair passes when carry out is low at the last master cycle of the clearing phase and high at the last master cycle of the applying phase. After each passing pair the count shrinks by a programmable step. The first failing pair ends the sweep, and the last passing count is reported. The reported count therefore approximates the shortest secondary period, in master cycles, that the adder sustains.

Top module: `clk_sweep_finder`

## Requirements
- R1: While busy, `sec_tick` is high for exactly one master cycle out of every P cycles, where P is the current count. The first tick of a sweep is high in the P-th cycle after the start edge.
- R2: After start, the operands are both zero (the clearing phase) and they switch phase on the edge that ends each tick cycle. In the applying phase `op_a` = 1 and `op_b` = all ones; in the clearing phase both are zero.
- R3: A pair fails if carry out is high in the tick cycle that ends its clearing phase, even when it is high again at the end of the applying phase.
- R4: A pair fails if carry out is low in the tick cycle that ends its applying phase.
- R5: After a passing pair with count P, the next count is P − step when P > step, and 1 otherwise. A step of 0 is treated as 1, and a maximum count of 0 is treated as 1.
- R6: On the first failing pair, `busy` falls and `done` rises on the same edge, and `result` holds the count of the last passing pair. All three then hold until the next start pulse.
- R7: If the pair at the maximum count fails, `no_pass` is set together with `done` and `result` is 0.
- R8: If the pair at count 1 passes, the sweep ends with `done` = 1, `result` = 1 and `no_pass` = 0.
- R9: While reset is asserted, `busy`, `done`, `no_pass`, `sec_tick`, `result` and both operands are zero.
- R10: A start pulse, even in mid-sweep, restarts the sweep from the maximum count. On the next edge `busy` = 1 and `done`, `no_pass` and `result` are cleared.
- R11: While not busy, both operands stay zero, and carry out and input changes have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins or restarts a sweep |
| max_count | input | CNT_W | Initial secondary period in master cycles |
| step | input | CNT_W | Amount the count shrinks after each passing pair |
| carry_out | input | 1 | Completion signal returned by the adder under test |
| op_a | output | OP_W | First adder operand |
| op_b | output | OP_W | Second adder operand |
| sec_tick | output | 1 | Terminal count of the divider (one secondary tick) |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished |
| no_pass | output | 1 | Not even the maximum count passed |
| result | output | CNT_W | Last passing count, 0 if none |

## Verification
The secondary tick is combinational from the divider count, so it is visible in the same cycle that the count reaches one. Operands, `done`, `no_pass` and `result` are registered and change on the edge that ends that tick cycle. Carry out is sampled on that same edge. The bench steps its behavioural model once per master edge using the inputs and carry value present just before that edge. It compares every output at the following falling edge, so each registered result is checked in the first cycle it is due. At the end of each sweep, the reported count is compared with the smallest swept count that exceeds the modelled adder latency.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  // Stimulus phase: clearing both operands, or applying the worst-case ripple input
  typedef enum logic {
    PH_CLEAR = 1'b0,
    PH_APPLY = 1'b1
  } phase_e;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic [CNT_W-1:0] reload_val,
  output logic             tick
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (tick) cnt_d = reload_val;
    else if (run)  cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/stim_sequencer.sv
module stim_sequencer
  import sweep_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            tick,
  input  logic            active,
  output phase_e          phase,
  output logic [OP_W-1:0] op_a,
  output logic [OP_W-1:0] op_b
);
  localparam logic [OP_W-1:0] A_APPLY = OP_W'(1);
  localparam logic [OP_W-1:0] B_APPLY = '1;

  phase_e          phase_d;
  logic [OP_W-1:0] op_a_d, op_b_d;

  always_comb begin
    phase_d = phase;
    if (restart)              phase_d = PH_CLEAR;
    else if (tick && active)  phase_d = (phase == PH_CLEAR) ? PH_APPLY : PH_CLEAR;
    op_a_d = (phase_d == PH_APPLY) ? A_APPLY : '0;
    op_b_d = (phase_d == PH_APPLY) ? B_APPLY : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CLEAR;
      op_a  <= '0;
      op_b  <= '0;
    end else begin
      phase <= phase_d;
      op_a  <= op_a_d;
      op_b  <= op_b_d;
    end
  end
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] max_count,
  input  logic [CNT_W-1:0] step,
  input  logic             tick,
  input  phase_e           phase,
  input  logic             carry,
  output logic             run,
  output logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] reload_val,
  output logic             done,
  output logic             no_pass,
  output logic [CNT_W-1:0] result
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run_d, done_d, nopass_d, clr_ok_q, clr_ok_d;
  logic [CNT_W-1:0] per_q, per_d, step_q, step_d, last_q, last_d, res_d;
  logic [CNT_W-1:0] max_c, step_c, shrunk;
  logic             pair_ok;

  assign max_c    = (max_count == '0) ? ONE : max_count;
  assign step_c   = (step == '0) ? ONE : step;
  assign shrunk   = (per_q > step_q) ? (per_q - step_q) : ONE;
  assign pair_ok  = clr_ok_q && carry;
  assign load_val = max_c;

  always_comb begin
    run_d    = run;
    per_d    = per_q;
    step_d   = step_q;
    last_d   = last_q;
    clr_ok_d = clr_ok_q;
    done_d   = done;
    nopass_d = no_pass;
    res_d    = result;
    if (start) begin
      run_d    = 1'b1;
      per_d    = max_c;
      step_d   = step_c;
      last_d   = '0;
      clr_ok_d = 1'b0;
      done_d   = 1'b0;
      nopass_d = 1'b0;
      res_d    = '0;
    end else if (tick) begin
      if (phase == PH_CLEAR) begin
        clr_ok_d = !carry;
      end else if (pair_ok && (per_q != ONE)) begin
        last_d = per_q;
        per_d  = shrunk;
      end else if (pair_ok) begin
        last_d = per_q;
        run_d  = 1'b0;
        done_d = 1'b1;
        res_d  = per_q;
      end else begin
        run_d    = 1'b0;
        done_d   = 1'b1;
        res_d    = last_q;
        nopass_d = (last_q == '0);
      end
    end
  end

  assign reload_val = per_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      per_q    <= '0;
      step_q   <= '0;
      last_q   <= '0;
      clr_ok_q <= 1'b0;
      done     <= 1'b0;
      no_pass  <= 1'b0;
      result   <= '0;
    end else begin
      run      <= run_d;
      per_q    <= per_d;
      step_q   <= step_d;
      last_q   <= last_d;
      clr_ok_q <= clr_ok_d;
      done     <= done_d;
      no_pass  <= nopass_d;
      result   <= res_d;
    end
  end
endmodule

// File: rtl/clk_sweep_finder.sv
module clk_sweep_finder
  import sweep_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] max_count,
  input  logic [CNT_W-1:0] step,
  input  logic             carry_out,
  output logic [OP_W-1:0]  op_a,
  output logic [OP_W-1:0]  op_b,
  output logic             sec_tick,
  output logic             busy,
  output logic             done,
  output logic             no_pass,
  output logic [CNT_W-1:0] result
);
  phase_e           phase;
  logic [CNT_W-1:0] load_val, reload_val;

  tick_divider #(.CNT_W(CNT_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .load_val   (load_val),
    .run        (busy),
    .reload_val (reload_val),
    .tick       (sec_tick)
  );

  stim_sequencer #(.OP_W(OP_W)) u_stim (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start),
    .tick    (sec_tick),
    .active  (busy),
    .phase   (phase),
    .op_a    (op_a),
    .op_b    (op_b)
  );

  sweep_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .max_count  (max_count),
    .step       (step),
    .tick       (sec_tick),
    .phase      (phase),
    .carry      (carry_out),
    .run        (busy),
    .load_val   (load_val),
    .reload_val (reload_val),
    .done       (done),
    .no_pass    (no_pass),
    .result     (result)
  );
endmodule

// File: rtl/sweep_checker.sv
module sweep_checker #(
  parameter int OP_W  = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [OP_W-1:0]  op_a,
  input logic [OP_W-1:0]  op_b,
  input logic             sec_tick,
  input logic             busy,
  input logic             done,
  input logic             no_pass,
  input logic [CNT_W-1:0] result
);
  localparam logic [OP_W-1:0] A_ONE = OP_W'(1);
  localparam logic [OP_W-1:0] B_ALL = '1;

  p_ops_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_a == '0) && (op_b == '0)) || ((op_a == A_ONE) && (op_b == B_ALL)));

  p_idle_ops_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ((op_a == '0) && (op_b == '0)));

  p_tick_needs_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> busy);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(sec_tick));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(result) && $stable(no_pass)));

  p_nopass_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    no_pass |-> (done && (result == '0)));

  p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done && !no_pass && (result == '0)));
endmodule

bind clk_sweep_finder sweep_checker #(.OP_W(OP_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .op_a     (op_a),
  .op_b     (op_b),
  .sec_tick (sec_tick),
  .busy     (busy),
  .done     (done),
  .no_pass  (no_pass),
  .result   (result)
);

// File: tb/sim_clk_sweep_finder.sv
module sim_clk_sweep_finder;
  localparam int CLK_PERIOD = 10;
  localparam int OP_W  = 8;
  localparam int CNT_W = 8;
  localparam logic [OP_W-1:0] B_ALL = '1;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [CNT_W-1:0] max_count;
  logic [CNT_W-1:0] step;
  logic             carry_out;
  logic [OP_W-1:0]  op_a, op_b;
  logic             sec_tick, busy, done, no_pass;
  logic [CNT_W-1:0] result;

  int n_checks = 0;
  int n_fail   = 0;

  // adder model: carry rises lat master cycles after the applying phase begins
  int   lat   = 1;
  logic stuck = 1'b0;
  int   age   = 0;

  // reference model state
  int m_run, m_phase, m_cnt, m_per, m_step, m_last, m_clr, m_done, m_np, m_res;
  int cfg_max, cfg_step;

  clk_sweep_finder #(.OP_W(OP_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .max_count(max_count), .step(step),
    .carry_out(carry_out), .op_a(op_a), .op_b(op_b), .sec_tick(sec_tick),
    .busy(busy), .done(done), .no_pass(no_pass), .result(result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) age <= (op_b == B_ALL) ? age + 1 : 0;
  assign carry_out = stuck | ((op_b == B_ALL) && (age >= lat));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step(input bit st);
    bit c;
    c = carry_out;
    if (st) begin
      m_run = 1; m_per = (cfg_max == 0) ? 1 : cfg_max; m_cnt = m_per;
      m_step = (cfg_step == 0) ? 1 : cfg_step;
      m_phase = 0; m_last = 0; m_clr = 0; m_done = 0; m_np = 0; m_res = 0;
    end else if (m_run != 0) begin
      if (m_cnt == 1) begin
        if (m_phase == 0) begin
          m_clr = !c; m_phase = 1; m_cnt = m_per;
        end else begin
          m_phase = 0;
          if (m_clr != 0 && c) begin
            m_last = m_per;
            if (m_per == 1) begin
              m_run = 0; m_done = 1; m_res = 1;
            end else begin
              m_per = (m_per > m_step) ? m_per - m_step : 1;
              m_cnt = m_per;
            end
          end else begin
            m_run = 0; m_done = 1; m_res = m_last; m_np = (m_last == 0);
          end
        end
      end else begin
        m_cnt--;
      end
    end
  endtask

  task automatic compare();
    bit exp_tick;
    logic [OP_W-1:0] ea, eb;
    exp_tick = (m_run != 0) && (m_cnt == 1);
    ea = (m_phase != 0) ? OP_W'(1) : '0;
    eb = (m_phase != 0) ? B_ALL : '0;
    check(sec_tick == exp_tick, "R1", "sec_tick", sec_tick, exp_tick);
    check(op_a == ea, "R2", "op_a", op_a, ea);
    check(op_b == eb, "R2", "op_b", op_b, eb);
    check(busy == (m_run != 0), "R10", "busy", busy, m_run);
    check(done == (m_done != 0), "R6", "done", done, m_done);
    check(result == CNT_W'(m_res), "R6", "result", result, m_res);
    check(no_pass == (m_np != 0), "R7", "no_pass", no_pass, m_np);
  endtask

  task automatic cyc(input bit st);
    start = st;
    model_step(st);
    @(negedge clk);
    compare();
  endtask

  function automatic int expect_res(input int mx, input int stp, input int l);
    int p, s, last;
    p = (mx == 0) ? 1 : mx;
    s = (stp == 0) ? 1 : stp;
    last = 0;
    forever begin
      if (p <= l) break;
      last = p;
      if (p == 1) break;
      p = (p > s) ? p - s : 1;
    end
    return last;
  endfunction

  task automatic run_sweep(input int mx, input int stp, input int l, input bit stk,
                           input string req);
    int er;
    bit done_seen;
    cfg_max = mx; cfg_step = stp; lat = l; stuck = stk;
    max_count = CNT_W'(mx); step = CNT_W'(stp);
    er = stk ? 0 : expect_res(mx, stp, l);
    cyc(1'b1);
    done_seen = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      cyc(1'b0);
      if (done) begin done_seen = 1'b1; break; end
    end
    check(done_seen, req, "sweep_finished", done_seen, 1);
    check(result == CNT_W'(er), req, "final_result", result, er);
    check(no_pass == (er == 0), req, "final_no_pass", no_pass, er == 0);
    // R11: input and carry changes while idle have no effect
    max_count = 8'd77; step = 8'd3; stuck = 1'b1;
    for (int i = 0; i < 12; i++) cyc(1'b0);
    check((op_a == '0) && (op_b == '0), "R11", "idle_ops", op_b, 0);
    check(result == CNT_W'(er), "R6", "held_result", result, er);
    stuck = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; max_count = '0; step = '0;
    cfg_max = 0; cfg_step = 0;
    m_run = 0; m_phase = 0; m_cnt = 0; m_per = 0; m_step = 0;
    m_last = 0; m_clr = 0; m_done = 0; m_np = 0; m_res = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy && !done && !no_pass && !sec_tick, "R9", "reset_flags",
          {busy, done, no_pass, sec_tick}, 0);
    check((result == '0) && (op_a == '0) && (op_b == '0), "R9", "reset_data", result, 0);
    rst_n = 1'b1;
    cyc(1'b0);
    // R4 and R5: 20,17,14,11,8 pass, 5 fails against latency 7
    run_sweep(20, 3, 7, 1'b0, "R4");
    // R5 floor: 10,6,2 with latency 3 gives 6
    run_sweep(10, 4, 3, 1'b0, "R5");
    // R8: step 0 treated as 1, every count passes down to 1
    run_sweep(5, 0, 0, 1'b0, "R8");
    // R7: maximum count already too short
    run_sweep(3, 1, 5, 1'b0, "R7");
    // R3: carry stuck high fails the clearing check
    run_sweep(12, 2, 1, 1'b1, "R3");
    // R5: maximum 0 treated as 1
    run_sweep(0, 2, 0, 1'b0, "R5");
    // R10: restart in mid-sweep
    cfg_max = 30; cfg_step = 5; lat = 4;
    max_count = 8'd30; step = 8'd5;
    cyc(1'b1);
    for (int i = 0; i < 25; i++) cyc(1'b0);
    check(busy, "R10", "busy_mid_sweep", busy, 1);
    run_sweep(9, 2, 2, 1'b0, "R10");
    // R6: far-off sweep with slow adder
    run_sweep(60, 7, 20, 1'b0, "R6");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule